// File: doc/BRIEF.md
# Interrupt Pending Gate and Winner Selector

This block sits between a core's interrupt sources and its exception entry logic. Hardware request lines are sampled into a status register every cycle, and two software interrupt bits are set or cleared through an indexed request port. A per-line enable mask, written over a simple register write port, selects which status bits count. The block then decides whether an interrupt may be taken, based on the global interrupt enable and the debug-state flag.

When an interrupt is taken, the block emits a one-cycle strobe and latches the index of the winning line. A separate wake indication tells a halted core that enabled work is waiting. The wake indication does not depend on the global enable or the debug flag. Vector address generation and context saving belong to the consumer of these outputs.

Top module: `irq_gate`

## Requirements
- R1: Status bit i, for i from SW_LINES to NUM_LINES-1, equals the value of hardware line `hw_lines[i-SW_LINES]` sampled at the previous clock edge. It keeps tracking while reset is held.
- R2: A software request (`req_valid`=1 with `req_idx` below SW_LINES) writes `req_level` into status bit `req_idx` at the next clock edge. It touches no other bit.
- R3: A software request whose `req_idx` is SW_LINES or above (for example 2 or 14) is ignored and leaves every status bit unchanged.
- R4: A line is pending when its status bit and its mask bit are both 1. The mask takes the value of `mask_wdata` at an edge where `mask_we`=1 and holds otherwise.
- R5: `take_o` can be 1 only if, in the cycle before, `glb_ie`=1, `dbg_mode`=0 and some line was pending.
- R6: `take_o` is a one-cycle pulse issued one edge after the take condition (R5) becomes true. It does not repeat while the condition stays true, and it fires again after the condition drops and returns.
- R7: With each take, `win_idx_o` is loaded with the highest-numbered pending line. It holds that value until the next take.
- R8: `wake_o` is 1 one edge after a cycle with `hard_req`=1 and at least one pending line. It is independent of `glb_ie` and `dbg_mode`.
- R9: Synchronous reset clears the mask, the software status bits, `take_o`, `win_idx_o` and `wake_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_lines | input | NUM_LINES-SW_LINES | Level-sensitive hardware request lines for lines SW_LINES and up |
| req_valid | input | 1 | Software interrupt request strobe |
| req_idx | input | REQ_IDX_W | Line addressed by the software request |
| req_level | input | 1 | Level written into the addressed software bit |
| mask_we | input | 1 | Enable-mask write strobe |
| mask_wdata | input | NUM_LINES | New enable-mask value |
| glb_ie | input | 1 | Global interrupt enable |
| dbg_mode | input | 1 | Core is in debug state; blocks taking |
| hard_req | input | 1 | Hard interrupt request seen by the halt logic |
| take_o | output | 1 | One-cycle take strobe |
| win_idx_o | output | $clog2(NUM_LINES) | Index of the line that won the last take |
| wake_o | output | 1 | Wake indication for a halted core |
| status_o | output | NUM_LINES | Current status register |

## Verification
The hardest case to reach is the one where the take condition stays true for many cycles while a higher line arrives. The strobe must stay quiet and the latched winner must not move. To get there, the stimulus holds the enable high with one line pending, raises a higher line, and then confirms no new strobe and an unchanged index. It then drops the global enable for one cycle and restores it, which should produce a fresh strobe carrying the new winner. Reset is also applied while a hardware line is high, so that cleared software bits and a still-tracking hardware bit can be seen side by side.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int DEF_NUM_LINES = 13;
  localparam int DEF_SW_LINES  = 2;
  localparam int DEF_REQ_IDX_W = 4;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int NUM_LINES = irq_gate_pkg::DEF_NUM_LINES,
  parameter int SW_LINES  = irq_gate_pkg::DEF_SW_LINES,
  parameter int REQ_IDX_W = irq_gate_pkg::DEF_REQ_IDX_W,
  localparam int HW_LINES = NUM_LINES - SW_LINES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [HW_LINES-1:0]  hw_lines,
  input  logic                 req_valid,
  input  logic [REQ_IDX_W-1:0] req_idx,
  input  logic                 req_level,
  output logic [NUM_LINES-1:0] status_o
);
  // software bits: reset, written only by an in-range request
  for (genvar i = 0; i < SW_LINES; i++) begin : g_sw
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        bit_q <= 1'b0;
      end else if (req_valid && (req_idx == REQ_IDX_W'(i))) begin
        bit_q <= req_level;
      end
    end
    assign status_o[i] = bit_q;
  end

  // hardware bits: plain samples of the lines, not reset
  for (genvar j = 0; j < HW_LINES; j++) begin : g_hw
    logic bit_q;
    always_ff @(posedge clk) begin
      bit_q <= hw_lines[j];
    end
    assign status_o[SW_LINES + j] = bit_q;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_LINES = irq_gate_pkg::DEF_NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
    end else if (we) begin
      mask_o <= wdata;
    end
  end
endmodule

// File: rtl/irq_priority_pick.sv
module irq_priority_pick #(
  parameter int NUM_LINES = irq_gate_pkg::DEF_NUM_LINES,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] active,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  // scan upward; the last hit is the highest index
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (active[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |active;
endmodule

// File: rtl/irq_take_ctrl.sv
module irq_take_ctrl #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic             glb_ie,
  input  logic             dbg_mode,
  input  logic             hard_req,
  input  logic [IDX_W-1:0] pick_idx,
  output logic             take_o,
  output logic [IDX_W-1:0] win_idx_o,
  output logic             wake_o
);
  logic eligible;
  logic elig_d;

  assign eligible = pending && glb_ie && !dbg_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      elig_d    <= 1'b0;
      take_o    <= 1'b0;
      win_idx_o <= '0;
      wake_o    <= 1'b0;
    end else begin
      elig_d <= eligible;
      take_o <= eligible && !elig_d;
      if (eligible && !elig_d) win_idx_o <= pick_idx;
      wake_o <= hard_req && pending;
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NUM_LINES = irq_gate_pkg::DEF_NUM_LINES,
  parameter int SW_LINES  = irq_gate_pkg::DEF_SW_LINES,
  parameter int REQ_IDX_W = irq_gate_pkg::DEF_REQ_IDX_W,
  localparam int HW_LINES = NUM_LINES - SW_LINES,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [HW_LINES-1:0]  hw_lines,
  input  logic                 req_valid,
  input  logic [REQ_IDX_W-1:0] req_idx,
  input  logic                 req_level,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] mask_wdata,
  input  logic                 glb_ie,
  input  logic                 dbg_mode,
  input  logic                 hard_req,
  output logic                 take_o,
  output logic [IDX_W-1:0]     win_idx_o,
  output logic                 wake_o,
  output logic [NUM_LINES-1:0] status_o
);
  logic [NUM_LINES-1:0] status_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] active;
  logic                 any_active;
  logic [IDX_W-1:0]     top_idx;

  irq_status_reg #(
    .NUM_LINES(NUM_LINES), .SW_LINES(SW_LINES), .REQ_IDX_W(REQ_IDX_W)
  ) u_status (
    .clk(clk), .rst(rst), .hw_lines(hw_lines),
    .req_valid(req_valid), .req_idx(req_idx), .req_level(req_level),
    .status_o(status_q)
  );

  irq_mask_reg #(.NUM_LINES(NUM_LINES)) u_mask (
    .clk(clk), .rst(rst), .we(mask_we), .wdata(mask_wdata), .mask_o(mask_q)
  );

  assign active = status_q & mask_q;

  irq_priority_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .active(active), .any_o(any_active), .idx_o(top_idx)
  );

  irq_take_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .pending(any_active), .glb_ie(glb_ie),
    .dbg_mode(dbg_mode), .hard_req(hard_req), .pick_idx(top_idx),
    .take_o(take_o), .win_idx_o(win_idx_o), .wake_o(wake_o)
  );

  assign status_o = status_q;
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int NUM_LINES = 13,
  parameter int SW_LINES  = 2,
  parameter int REQ_IDX_W = 4,
  localparam int HW_LINES = NUM_LINES - SW_LINES,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [HW_LINES-1:0]  hw_lines,
  input logic                 req_valid,
  input logic [REQ_IDX_W-1:0] req_idx,
  input logic                 glb_ie,
  input logic                 dbg_mode,
  input logic                 hard_req,
  input logic [NUM_LINES-1:0] status,
  input logic [NUM_LINES-1:0] mask,
  input logic                 take,
  input logic [IDX_W-1:0]     win_idx,
  input logic                 wake
);
  logic [NUM_LINES-1:0] act_d;
  logic                 sw_req_in_range;

  always_ff @(posedge clk) act_d <= status & mask;
  assign sw_req_in_range = req_valid && (int'(req_idx) < SW_LINES);

  p_hw_follow_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> status[NUM_LINES-1:SW_LINES] == $past(hw_lines));

  p_sw_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sw_req_in_range)) |->
      status[SW_LINES-1:0] == $past(status[SW_LINES-1:0]));

  p_take_gate_r5: assert property (@(posedge clk) disable iff (rst)
    take |-> ($past(glb_ie) && !$past(dbg_mode) && ($past(status & mask) != '0)));

  p_take_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);

  p_win_top_r7: assert property (@(posedge clk) disable iff (rst)
    take |-> ((act_d >> win_idx) == NUM_LINES'(1)));

  p_win_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !take) |-> $stable(win_idx));

  p_wake_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> wake == ($past(hard_req) && ($past(status & mask) != '0)));
endmodule

bind irq_gate irq_gate_chk #(
  .NUM_LINES(NUM_LINES), .SW_LINES(SW_LINES), .REQ_IDX_W(REQ_IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .hw_lines(hw_lines), .req_valid(req_valid),
  .req_idx(req_idx), .glb_ie(glb_ie), .dbg_mode(dbg_mode),
  .hard_req(hard_req), .status(status_o), .mask(mask_q),
  .take(take_o), .win_idx(win_idx_o), .wake(wake_o)
);

// File: tb/irq_gate_test.sv
`timescale 1ns/1ps
module irq_gate_test;
  localparam int N  = 13;
  localparam int SW = 2;
  localparam int RW = 4;
  localparam int HW = N - SW;
  localparam int IW = $clog2(N);

  typedef struct packed {
    logic [N-1:0]  lines;
    logic [N-1:0]  mask;
    logic          ie;
    logic          dbg;
    logic          hard;
    logic          e_take;
    logic [IW-1:0] e_idx;
    logic          e_wake;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{13'h0004, 13'h1FFF, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2,  1'b1},
    '{13'h1004, 13'h1FFF, 1'b1, 1'b0, 1'b1, 1'b1, 4'd12, 1'b1},
    '{13'h1004, 13'h0FFF, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2,  1'b0},
    '{13'h0FF0, 13'h00FF, 1'b1, 1'b0, 1'b1, 1'b1, 4'd7,  1'b1},
    '{13'h0FF0, 13'h000F, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  1'b0},
    '{13'h0100, 13'h1FFF, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  1'b1},
    '{13'h0100, 13'h1FFF, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0,  1'b1},
    '{13'h0100, 13'h1FFF, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8,  1'b0},
    '{13'h0A00, 13'h0200, 1'b1, 1'b0, 1'b0, 1'b1, 4'd9,  1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [HW-1:0] hw_lines = '0;
  logic          req_valid = 1'b0;
  logic [RW-1:0] req_idx = '0;
  logic          req_level = 1'b0;
  logic          mask_we = 1'b0;
  logic [N-1:0]  mask_wdata = '0;
  logic          glb_ie = 1'b0;
  logic          dbg_mode = 1'b0;
  logic          hard_req = 1'b0;
  logic          take_o;
  logic [IW-1:0] win_idx_o;
  logic          wake_o;
  logic [N-1:0]  status_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_gate uut (
    .clk(clk), .rst(rst), .hw_lines(hw_lines), .req_valid(req_valid),
    .req_idx(req_idx), .req_level(req_level), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .glb_ie(glb_ie), .dbg_mode(dbg_mode),
    .hard_req(hard_req), .take_o(take_o), .win_idx_o(win_idx_o),
    .wake_o(wake_o), .status_o(status_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic write_mask(input logic [N-1:0] m);
    mask_we = 1'b1; mask_wdata = m;
    tick(1);
    mask_we = 1'b0;
  endtask

  task automatic sw_req(input logic [RW-1:0] idx, input logic lvl);
    req_valid = 1'b1; req_idx = idx; req_level = lvl;
    tick(1);
    req_valid = 1'b0;
  endtask

  initial begin
    tick(2);
    // R9: reset state
    check("R9", "take in reset", 32'(take_o), 0);
    check("R9", "wake in reset", 32'(wake_o), 0);
    check("R9", "win in reset", 32'(win_idx_o), 0);
    check("R9", "status in reset", 32'(status_o), 0);
    rst = 1'b0;
    tick(1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      hw_lines = '0; glb_ie = 1'b0; dbg_mode = 1'b0; hard_req = 1'b0;
      write_mask(TBL[v].mask);
      tick(2);
      hw_lines = TBL[v].lines[N-1:SW];
      glb_ie = TBL[v].ie; dbg_mode = TBL[v].dbg; hard_req = TBL[v].hard;
      tick(2);
      check("R5", $sformatf("take v%0d", v), 32'(take_o), 32'(TBL[v].e_take));
      if (TBL[v].e_take)
        check("R7", $sformatf("win v%0d", v), 32'(win_idx_o), 32'(TBL[v].e_idx));
      check("R8", $sformatf("wake v%0d", v), 32'(wake_o), 32'(TBL[v].e_wake));
      check("R4", $sformatf("status v%0d", v), 32'(status_o), 32'(TBL[v].lines & 13'h1FFC));
      tick(1);
      check("R6", $sformatf("pulse end v%0d", v), 32'(take_o), 0);
    end

    // software lines
    hw_lines = '0; glb_ie = 1'b0; dbg_mode = 1'b0; hard_req = 1'b0;
    write_mask(13'h0003);
    tick(2);
    sw_req(4'd1, 1'b1);
    check("R2", "sw bit1 set", 32'(status_o), 32'h0002);
    glb_ie = 1'b1;
    tick(1);
    check("R2", "sw take", 32'(take_o), 1);
    check("R7", "sw winner", 32'(win_idx_o), 1);
    sw_req(4'd14, 1'b0);
    check("R3", "idx 14 ignored", 32'(status_o), 32'h0002);
    sw_req(4'd2, 1'b1);
    check("R3", "idx 2 ignored", 32'(status_o), 32'h0002);
    sw_req(4'd1, 1'b0);
    check("R2", "sw bit1 clear", 32'(status_o), 0);

    // pulse and winner hold while eligibility persists
    glb_ie = 1'b0;
    write_mask(13'h1FFF);
    tick(1);
    hw_lines = 11'h004;  // line 4
    glb_ie = 1'b1;
    tick(2);
    check("R6", "first take", 32'(take_o), 1);
    check("R7", "first winner", 32'(win_idx_o), 4);
    hw_lines = 11'h104;  // lines 4 and 10
    tick(2);
    check("R6", "no retake", 32'(take_o), 0);
    check("R7", "winner held", 32'(win_idx_o), 4);
    tick(3);
    check("R6", "still quiet", 32'(take_o), 0);
    glb_ie = 1'b0;
    tick(1);
    glb_ie = 1'b1;
    tick(1);
    check("R6", "retake", 32'(take_o), 1);
    check("R7", "new winner", 32'(win_idx_o), 10);

    // R1 and R9: reset mid-run with a hardware line high
    glb_ie = 1'b0; hw_lines = '0;
    sw_req(4'd0, 1'b1);
    tick(1);
    rst = 1'b1;
    hw_lines = 11'h010;  // line 6
    tick(1);
    check("R9", "sw bit cleared", 32'(status_o[0]), 0);
    check("R1", "hw tracks in reset", 32'(status_o[6]), 1);
    check("R9", "winner cleared", 32'(win_idx_o), 0);
    rst = 1'b0;
    glb_ie = 1'b1; hard_req = 1'b1;
    tick(2);
    check("R9", "mask cleared, no take", 32'(take_o), 0);
    check("R9", "mask cleared, no wake", 32'(wake_o), 0);
    hw_lines = '0;
    tick(1);
    check("R1", "hw line drop", 32'(status_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule